// File: doc/BRIEF.md
# Test Pin Source Selector with Clock-Bypass Control

This block chooses what a synthesizer's single test pin shows. A 3-bit test code picks one of eight sources: the bit leaving the serial configuration shift register, a fixed high, a fixed low, the phase-detector reference, the loop counter output, the synthesizer output, or that output divided by four. The eighth code does not pick a plain source. It puts the part into a clock-bypass mode. In that mode the serial clock replaces the oscillator as the clock for both the loop divider and the output divider, and the loop divider's terminal-count pulse is sent to the test pin.

The test code is held in a select register. A serial load strobe writes it. While the active-low parallel-load input is low, the register is held cleared, so the pin shows the shift register's outgoing bit. Every clock-like source is treated as a level and sampled on the block clock. The bypass steering flag changes only in a cycle in which the serial clock is sampled low, so the divider clock source always switches while that clock is low. The loop counter inside the block is a down-counter that reloads from the programmed modulus. It advances on serial-clock rising edges only while bypass is active.

Top module: `test_pin_select`

## Requirements
- R1: While reset is asserted and after it ends, `test_out` and `bypass_sel` are 0 and the stored test code is 000.
- R2: A cycle with `code_load` high and `par_load_n` high stores `test_code`. The new source appears on `test_out` two clock edges after the load cycle.
- R3: While `par_load_n` is low, the stored code is forced to 000 and `code_load` has no effect. `test_out` then follows `shift_msb`.
- R4: Codes 000, 001, 010 and 011 drive `test_out` with `shift_msb`, constant 1, `ref_clk_in` and `mcnt_in`. `test_out` lags the source by one edge.
- R5: Codes 100, 101 and 111 drive `test_out` with `fout_in`, constant 0 and `fout_div4_in`. `test_out` lags the source by one edge.
- R6: Code 110 asserts `bypass_sel` and routes the internal loop-counter pulse to `test_out`. Under code 110 without bypass active, `test_out` stays 0.
- R7: `bypass_sel` changes only on an edge at which `ser_clk_in` is sampled 0. While `ser_clk_in` stays high, a change of code leaves `bypass_sel` unchanged.
- R8: In bypass, the counter emits one pulse, one clock wide, for every `m_value` rising edges of `ser_clk_in`. A pulse comes on the `m_value`-th edge after bypass is entered. `m_value` = 1 gives a pulse on every edge.
- R9: Outside bypass, the counter is held at its reload value. Serial-clock edges seen outside bypass therefore do not shift the pulse phase after the next entry into bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_load_n | input | 1 | Parallel-load level; when low, the stored code is held cleared |
| code_load | input | 1 | Serial latch strobe; stores `test_code` |
| test_code | input | 3 | Test code from the serial configuration stream |
| shift_msb | input | 1 | Bit leaving the serial shift register |
| ref_clk_in | input | 1 | Phase-detector reference, sampled as a level |
| mcnt_in | input | 1 | Loop counter output from the PLL path |
| fout_in | input | 1 | Synthesizer output clock, sampled as a level |
| fout_div4_in | input | 1 | Output clock divided by four |
| ser_clk_in | input | 1 | Serial clock; counted in bypass |
| m_value | input | 7 | Programmed loop-divider modulus (0 acts as 128) |
| test_out | output | 1 | Registered test pin value |
| bypass_sel | output | 1 | Steers both dividers onto the serial clock |

## Verification
The assertions assume that `ser_clk_in` is a slow level, far below the block clock, so that every high and every low phase lasts at least one block clock. The one-clock pulse width and the switch-while-low rule both depend on this. The stimulus drives the serial clock one block cycle high and then one block cycle low. It changes the test code only through the load strobe, and only while the parallel-load level is settled.

// File: rtl/test_pin_select_pkg.sv
package test_pin_select_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        TS_SHIFT  = 3'b000,
        TS_HIGH   = 3'b001,
        TS_REF    = 3'b010,
        TS_MCNT   = 3'b011,
        TS_FOUT   = 3'b100,
        TS_LOW    = 3'b101,
        TS_BYPASS = 3'b110,
        TS_FDIV4  = 3'b111
    } tsel_code_e;

endpackage

// File: rtl/tsel_code_latch.sv
module tsel_code_latch
    import test_pin_select_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_load_n,
    input  logic              code_load,
    input  logic [CODE_W-1:0] code_in,
    output tsel_code_e        sel
);

    typedef struct packed {
        tsel_code_e code;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!par_load_n) begin
            st_d.code = TS_SHIFT;
        end else if (code_load) begin
            st_d.code = tsel_code_e'(code_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{code: TS_SHIFT};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel = st_q.code;

    // R2: a strobe with parallel load released stores the code
    a_r2_code_store: assert property (@(posedge clk) disable iff (!rst_n)
        (code_load && par_load_n) |=> (sel == tsel_code_e'($past(code_in))));

    // R3: parallel load low forces the shift-out selection
    a_r3_forced_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_load_n) |=> (sel == TS_SHIFT));

endmodule

// File: rtl/tsel_bypass_ctrl.sv
module tsel_bypass_ctrl #(
    parameter int M_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           want_bypass,
    input  logic           ser_clk_in,
    input  logic [M_W-1:0] m_value,
    output logic           bypass_sel,
    output logic           mcnt_pulse
);

    localparam logic [M_W-1:0] ONE = M_W'(1);

    typedef struct packed {
        logic           bypass;
        logic           sclk;
        logic [M_W-1:0] cnt;
        logic           pulse;
    } byp_st_t;

    byp_st_t st_d, st_q;
    logic    sclk_rise;

    always_comb begin
        st_d      = st_q;
        sclk_rise = ser_clk_in && !st_q.sclk;
        st_d.sclk  = ser_clk_in;
        st_d.pulse = 1'b0;
        // steering moves only while the serial clock is low
        if (!ser_clk_in) begin
            st_d.bypass = want_bypass;
        end
        if (!st_q.bypass) begin
            st_d.cnt = m_value - ONE;
        end else if (sclk_rise) begin
            if (st_q.cnt == '0) begin
                st_d.cnt   = m_value - ONE;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{bypass: 1'b0, sclk: 1'b0, cnt: '0, pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bypass_sel = st_q.bypass;
    assign mcnt_pulse = st_q.pulse;

    // R7: the steering flag moves only after a low serial-clock sample
    a_r7_clean_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_sel != $past(bypass_sel)) |-> !$past(ser_clk_in));

    // R8: the terminal-count pulse lasts one clock
    a_r8_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        mcnt_pulse |=> !mcnt_pulse);

    // R9: no pulse is produced outside bypass
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass_sel |=> !mcnt_pulse);

endmodule

// File: rtl/tsel_mux.sv
module tsel_mux
    import test_pin_select_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  tsel_code_e sel,
    input  logic       shift_msb,
    input  logic       ref_in,
    input  logic       mcnt_in,
    input  logic       fout_in,
    input  logic       fdiv4_in,
    input  logic       byp_pulse,
    output logic       test_out
);

    typedef struct packed {
        logic pin;
    } mux_st_t;

    mux_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (sel)
            TS_SHIFT:  st_d.pin = shift_msb;
            TS_HIGH:   st_d.pin = 1'b1;
            TS_REF:    st_d.pin = ref_in;
            TS_MCNT:   st_d.pin = mcnt_in;
            TS_FOUT:   st_d.pin = fout_in;
            TS_LOW:    st_d.pin = 1'b0;
            TS_BYPASS: st_d.pin = byp_pulse;
            TS_FDIV4:  st_d.pin = fdiv4_in;
            default:   st_d.pin = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pin: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign test_out = st_q.pin;

    // R4: the fixed-high code drives the pin high
    a_r4_const_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == TS_HIGH) |=> test_out);

    // R5: the fixed-low code drives the pin low
    a_r5_const_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == TS_LOW) |=> !test_out);

endmodule

// File: rtl/test_pin_select.sv
module test_pin_select
    import test_pin_select_pkg::*;
#(
    parameter int M_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_load_n,
    input  logic              code_load,
    input  logic [CODE_W-1:0] test_code,
    input  logic              shift_msb,
    input  logic              ref_clk_in,
    input  logic              mcnt_in,
    input  logic              fout_in,
    input  logic              fout_div4_in,
    input  logic              ser_clk_in,
    input  logic [M_W-1:0]    m_value,
    output logic              test_out,
    output logic              bypass_sel
);

    tsel_code_e sel;
    logic       byp_pulse;

    tsel_code_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .par_load_n (par_load_n),
        .code_load  (code_load),
        .code_in    (test_code),
        .sel        (sel)
    );

    tsel_bypass_ctrl #(.M_W(M_W)) u_bypass (
        .clk         (clk),
        .rst_n       (rst_n),
        .want_bypass (sel == TS_BYPASS),
        .ser_clk_in  (ser_clk_in),
        .m_value     (m_value),
        .bypass_sel  (bypass_sel),
        .mcnt_pulse  (byp_pulse)
    );

    tsel_mux u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .shift_msb (shift_msb),
        .ref_in    (ref_clk_in),
        .mcnt_in   (mcnt_in),
        .fout_in   (fout_in),
        .fdiv4_in  (fout_div4_in),
        .byp_pulse (byp_pulse),
        .test_out  (test_out)
    );

    // R6: bypass is only entered when the bypass code was selected
    a_r6_bypass_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bypass_sel) |-> $past(sel == TS_BYPASS));

endmodule

// File: tb/test_pin_select_tb_top.sv
module test_pin_select_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_load_n = 1'b1;
    logic       code_load = 1'b0;
    logic [2:0] test_code = 3'b000;
    logic       shift_msb = 1'b0;
    logic       ref_clk_in = 1'b0;
    logic       mcnt_in = 1'b0;
    logic       fout_in = 1'b0;
    logic       fout_div4_in = 1'b0;
    logic       ser_clk_in = 1'b0;
    logic [6:0] m_value = 7'd3;
    logic       test_out;
    logic       bypass_sel;

    int n_checks = 0;
    int n_fail = 0;
    int pcount = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    test_pin_select dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .par_load_n   (par_load_n),
        .code_load    (code_load),
        .test_code    (test_code),
        .shift_msb    (shift_msb),
        .ref_clk_in   (ref_clk_in),
        .mcnt_in      (mcnt_in),
        .fout_in      (fout_in),
        .fout_div4_in (fout_div4_in),
        .ser_clk_in   (ser_clk_in),
        .m_value      (m_value),
        .test_out     (test_out),
        .bypass_sel   (bypass_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load_code(input logic [2:0] c);
        @(negedge clk);
        test_code = c;
        code_load = 1'b1;
        @(negedge clk);
        code_load = 1'b0;
    endtask

    task automatic drive_src(input logic [2:0] c, input logic v);
        case (c)
            3'b000: shift_msb = v;
            3'b010: ref_clk_in = v;
            3'b011: mcnt_in = v;
            3'b100: fout_in = v;
            3'b111: fout_div4_in = v;
            default: ;
        endcase
    endtask

    task automatic sample_step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (test_out) pcount++;
        end
    endtask

    task automatic ser_edges(input int n);
        for (int i = 0; i < n; i++) begin
            ser_clk_in = 1'b1;
            sample_step(1);
            ser_clk_in = 1'b0;
            sample_step(1);
        end
    endtask

    // R1: reset values, then code 000 shows the shift bit
    task automatic t_reset();
        shift_msb = 1'b1;
        step(2);
        chk("R1 test_out in reset", test_out, 0);
        chk("R1 bypass_sel in reset", bypass_sel, 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 code 000 after reset", test_out, 1);
        chk("R1 bypass_sel after reset", bypass_sel, 0);
    endtask

    // R2 R4 R5: each plain code passes its source through
    task automatic t_codes();
        logic [2:0] list [7] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b111};
        for (int k = 0; k < 7; k++) begin
            load_code(list[k]);
            drive_src(list[k], 1'b1);
            step(1);
            chk($sformatf("R2 R4 R5 code %0d high phase", list[k]), test_out,
                (list[k] == 3'b101) ? 0 : 1);
            drive_src(list[k], 1'b0);
            step(1);
            chk($sformatf("R4 R5 code %0d low phase", list[k]), test_out,
                (list[k] == 3'b001) ? 1 : 0);
        end
    endtask

    // R3: parallel load low overrides the strobe
    task automatic t_par_override();
        load_code(3'b001);
        step(1);
        chk("R3 precondition code 001", test_out, 1);
        @(negedge clk);
        par_load_n = 1'b0;
        code_load = 1'b1;
        test_code = 3'b101;
        shift_msb = 1'b0;
        step(2);
        chk("R3 forced to shift bit low", test_out, 0);
        shift_msb = 1'b1;
        step(1);
        chk("R3 forced to shift bit high", test_out, 1);
        code_load = 1'b0;
        par_load_n = 1'b1;
        shift_msb = 1'b0;
        step(1);
    endtask

    // R6 R7 R8 R9: bypass entry, counting, reload
    task automatic t_bypass();
        m_value = 7'd3;
        ser_clk_in = 1'b1;
        load_code(3'b110);
        step(3);
        chk("R7 no switch while serial clock high", bypass_sel, 0);
        chk("R6 code 110 outside bypass gives 0", test_out, 0);
        ser_clk_in = 1'b0;
        step(1);
        chk("R6 R7 bypass entered on low sample", bypass_sel, 1);
        pcount = 0;
        ser_edges(2);
        sample_step(2);
        chk("R8 no pulse before edge M", pcount, 0);
        ser_edges(1);
        sample_step(2);
        chk("R8 one pulse on edge M", pcount, 1);
        ser_edges(6);
        sample_step(2);
        chk("R8 one pulse per M edges", pcount, 3);
        // R9: partial count, leave, toggle, return
        pcount = 0;
        ser_edges(2);
        ser_clk_in = 1'b1;
        load_code(3'b000);
        step(3);
        chk("R7 exit held while serial clock high", bypass_sel, 1);
        ser_clk_in = 1'b0;
        step(2);
        chk("R7 exit on low sample", bypass_sel, 0);
        ser_edges(5);
        load_code(3'b110);
        step(3);
        chk("R6 bypass re-entered", bypass_sel, 1);
        pcount = 0;
        ser_edges(2);
        sample_step(2);
        chk("R9 counter reloaded outside bypass", pcount, 0);
        ser_edges(1);
        sample_step(2);
        chk("R9 first pulse M edges after entry", pcount, 1);
        // R8 boundary: modulus 1
        load_code(3'b000);
        step(3);
        m_value = 7'd1;
        load_code(3'b110);
        step(3);
        pcount = 0;
        ser_edges(4);
        sample_step(2);
        chk("R8 modulus 1 pulses every edge", pcount, 4);
    endtask

    initial begin
        t_reset();
        t_codes();
        t_par_override();
        t_bypass();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule